// File: doc/BRIEF.md
# Coherency Unit Configuration Registers

This block is the register face of a multicore coherency unit. It decodes a 256-byte address window on a simple synchronous bus. Each cycle the bus may raise a read strobe, a write strobe or both. A write carries an access size of 1, 2 or 4 bytes. The block keeps three pieces of state:

- a one-bit enable control;
- a read-only configuration word built from the core-count parameter;
- a 32-bit per-core power status word.

Software updates the power status word one byte lane at a time, or two or four lanes at once. The filtering, access-control and invalidate locations are present but hold nothing. Any other offset is treated the same way.

Read data comes back one clock after the read strobe, together with a one-cycle valid pulse. The functional reset clears the control bit and the read port. The power status word is left untouched by that reset, and it starts at zero only at power-up.

Top module: `cohu_regs`

## Requirements
- R1: Offset 0x00 keeps only bit 0 of a write; a read there returns that bit in bit 0, with zeros above it.
- R2: Offset 0x04 is read-only and returns NUM_CORES ones in bits 4 upward, ORed with NUM_CORES-1 in bits 1:0. With NUM_CORES=3 it reads 0x72. Writes to it change nothing.
- R3: The size input is the byte count as a 3-bit number, giving byte masks 0xFF, 0xFFFF and 0xFFFFFFFF for 1, 2 and 4. A write with any other size value leaves all state unchanged.
- R4: A write at offset 0x08+k (k = 0..3) updates the status word under the size mask shifted left by 8*k, from write data masked and shifted the same way. Bits pushed above bit 31 are lost. Bits outside the shifted mask keep their value.
- R5: A read at 0x08+k returns the status word shifted right by 8*k, with no masking of the upper bits.
- R6: Offsets 0x0C, 0x40, 0x44, 0x50, 0x54 and every offset not named in R1, R2 and R4 read as zero. Writes to them change no state.
- R7: While rst_n is low, the control bit, rvalid and rdata are zero. The power status word keeps its value through the reset.
- R8: rvalid is high exactly in the cycle after a read strobe, with rdata valid in that cycle. Otherwise rdata is zero. A read returns the state from before a write issued in the same cycle.
- R9: The power status word holds zero after power-up, before any write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous functional reset, active low |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Byte offset in the window |
| size | input | 3 | Write access size in bytes |
| wdata | input | 32 | Write data, right-aligned |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid pulse |

## Verification
Because reads are registered, a wrong status byte, a stray bit in the control bit or an error in the configuration formula appears on rdata one cycle after the next read of that offset. A reference model in the bench predicts that value. A write that leaks into the wrong lane, or that should have been dropped, stays hidden until a read of that offset. For that reason the bench reads the whole word and every lane offset after each lane write, and reads the control and status offsets again after writes to the holes and writes with a bad size. Correct rvalid timing is checked on every clock.

// File: rtl/cohu_pkg.sv
package cohu_pkg;
   // Offsets the decoder depends on
   localparam int unsigned OFF_CTRL = 'h00;
   localparam int unsigned OFF_CFG  = 'h04;
   localparam int unsigned OFF_STAT = 'h08;   // four lane offsets from here

   typedef enum logic [1:0] {
      REG_NONE = 2'd0,
      REG_CTRL = 2'd1,
      REG_CFG  = 2'd2,
      REG_STAT = 2'd3
   } region_e;
endpackage

// File: rtl/cohu_wmask.sv
module cohu_wmask #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned SIZE_W = 3
) (
   input  logic [SIZE_W-1:0] size,
   output logic [DATA_W-1:0] mask,
   output logic              ok
);
   if (DATA_W != 32) begin : g_bad_width
      $error("cohu_wmask: DATA_W must be 32");
   end

   always_comb begin
      mask = '0;
      ok   = 1'b0;
      unique case (size)
         SIZE_W'(1): begin mask = DATA_W'(32'h0000_00FF); ok = 1'b1; end
         SIZE_W'(2): begin mask = DATA_W'(32'h0000_FFFF); ok = 1'b1; end
         SIZE_W'(4): begin mask = '1;                     ok = 1'b1; end
         default:    begin mask = '0;                     ok = 1'b0; end
      endcase
   end

   // R3
   always_comb begin
      lane0_full_chk : assert (!ok || mask[7:0] == 8'hFF)
         else $error("accepted size without a full low byte mask");
   end
endmodule

// File: rtl/cohu_cfg_word.sv
module cohu_cfg_word #(
   parameter int unsigned NUM_CORES = 1,
   parameter int unsigned DATA_W    = 32
) (
   output logic [DATA_W-1:0] word
);
   localparam int unsigned CNT_W  = 2;
   localparam int unsigned MASK_LO = 4;
   localparam logic [CNT_W-1:0] CNT_ENC = CNT_W'(NUM_CORES - 1);

   if (NUM_CORES < 1 || NUM_CORES > 4) begin : g_bad_cores
      $error("cohu_cfg_word: NUM_CORES must be 1..4");
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b >= MASK_LO && b < MASK_LO + NUM_CORES) begin : g_core
         assign word[b] = 1'b1;
      end else if (b < CNT_W) begin : g_cnt
         assign word[b] = CNT_ENC[b];
      end else begin : g_zero
         assign word[b] = 1'b0;
      end
   end
endmodule

// File: rtl/cohu_pwr_status.sv
module cohu_pwr_status #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LANE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [LANE_W-1:0] lane,
   input  logic [DATA_W-1:0] mask,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   localparam int unsigned SH_W = LANE_W + 3;

   logic [SH_W-1:0]   sh;
   logic [DATA_W-1:0] m_sh;
   logic [DATA_W-1:0] d_sh;
   logic [DATA_W-1:0] q_r = '0;   // power-up value; functional reset leaves it

   assign sh   = {lane, 3'b000};
   assign m_sh = mask << sh;
   assign d_sh = (wdata & mask) << sh;

   always_ff @(posedge clk) begin
      if (we) begin
         q_r <= (q_r & ~m_sh) | d_sh;
      end
   end

   assign q = q_r;

   // R3
   idle_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));

   // R4
   lane_keep_chk : assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((q ^ $past(q)) & ~$past(m_sh)) == '0);
endmodule

// File: rtl/cohu_regs.sv
module cohu_regs #(
   parameter int unsigned NUM_CORES = 1,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned WIN_BYTES = 256,
   parameter int unsigned SIZE_W    = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         rd_en,
   input  logic                         wr_en,
   input  logic [$clog2(WIN_BYTES)-1:0] addr,
   input  logic [SIZE_W-1:0]            size,
   input  logic [DATA_W-1:0]            wdata,
   output logic [DATA_W-1:0]            rdata,
   output logic                         rvalid
);
   import cohu_pkg::*;

   localparam int unsigned ADDR_W = $clog2(WIN_BYTES);
   localparam int unsigned LANE_W = $clog2(DATA_W / 8);

   if (WIN_BYTES < 128 || (1 << ADDR_W) != WIN_BYTES) begin : g_bad_win
      $error("cohu_regs: WIN_BYTES must be a power of two of at least 128");
   end
   if (DATA_W != 32) begin : g_bad_width
      $error("cohu_regs: DATA_W must be 32");
   end

   region_e           region;
   logic [DATA_W-1:0] wmask;
   logic              size_ok;
   logic              wr_ok;
   logic              ctrl_q;
   logic [DATA_W-1:0] cfg_word;
   logic [DATA_W-1:0] stat_q;
   logic [DATA_W-1:0] rmux;
   logic [DATA_W-1:0] rdata_q;
   logic              rvalid_q;

   // Offset decode
   always_comb begin
      if (addr == ADDR_W'(OFF_CTRL))
         region = REG_CTRL;
      else if (addr == ADDR_W'(OFF_CFG))
         region = REG_CFG;
      else if (addr[ADDR_W-1:LANE_W] == (ADDR_W - LANE_W)'(OFF_STAT >> LANE_W))
         region = REG_STAT;
      else
         region = REG_NONE;
   end

   cohu_wmask #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_wmask (
      .size (size),
      .mask (wmask),
      .ok   (size_ok)
   );

   cohu_cfg_word #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) u_cfg (
      .word (cfg_word)
   );

   assign wr_ok = wr_en && size_ok;

   cohu_pwr_status #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_ok && region == REG_STAT),
      .lane  (addr[LANE_W-1:0]),
      .mask  (wmask),
      .wdata (wdata),
      .q     (stat_q)
   );

   // Control bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= 1'b0;
      else if (wr_ok && region == REG_CTRL)
         ctrl_q <= wdata[0];
   end

   // Read mux (pre-write state)
   always_comb begin
      unique case (region)
         REG_CTRL: rmux = {{(DATA_W-1){1'b0}}, ctrl_q};
         REG_CFG:  rmux = cfg_word;
         REG_STAT: rmux = stat_q >> {addr[LANE_W-1:0], 3'b000};
         default:  rmux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= rd_en;
         rdata_q  <= rd_en ? rmux : '0;
      end
   end

   assign rdata  = rdata_q;
   assign rvalid = rvalid_q;

   // R1
   ctrl_store_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && size_ok && addr == ADDR_W'(OFF_CTRL)) |=> ctrl_q == $past(wdata[0]));

   // R2
   cfg_read_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (rvalid && $past(region) == REG_CFG) |-> rdata == cfg_word);

   // R5
   stat_full_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (rvalid && $past(region) == REG_STAT && $past(addr[LANE_W-1:0]) == '0)
         |-> rdata == $past(stat_q));

   // R6
   hole_zero_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (rvalid && $past(region) == REG_NONE) |-> rdata == '0);

   // R8
   rvalid_follow_chk : assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rvalid);
endmodule

// File: tb/sim_cohu_regs.sv
`timescale 1ns/1ps
module sim_cohu_regs;
   localparam int NCORE = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [2:0]  size = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        rvalid;

   int errors = 0;
   int checks = 0;
   int ticks  = 0;
   bit done   = 1'b0;

   // reference model state
   bit          m_ctrl = 1'b0;
   logic [31:0] m_stat = '0;

   always #2 clk = ~clk;

   cohu_regs #(.NUM_CORES(NCORE)) u0 (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
      .size(size), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
   );

   always @(posedge clk) begin
      ticks++;
      if (ticks > 20000 && !done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] m_read(logic [7:0] a);
      int k;
      if (a == 8'h00) return {31'b0, m_ctrl};
      if (a == 8'h04) return 32'((((1 << NCORE) - 1) << 4) | (NCORE - 1));
      if (a >= 8'h08 && a <= 8'h0B) begin
         k = int'(a) - 8;
         return m_stat >> (8 * k);
      end
      return 32'h0;
   endfunction

   function automatic void m_write(logic [7:0] a, logic [2:0] s, logic [31:0] d);
      logic [31:0] m;
      int k;
      if (s == 3'd1) m = 32'hFF;
      else if (s == 3'd2) m = 32'hFFFF;
      else if (s == 3'd4) m = 32'hFFFF_FFFF;
      else return;
      if (a == 8'h00) m_ctrl = d[0];
      else if (a >= 8'h08 && a <= 8'h0B) begin
         k = int'(a) - 8;
         m_stat = (m_stat & ~(m << (8 * k))) | ((d & m) << (8 * k));
      end
   endfunction

   // One bus cycle: drive at a falling edge, compare at the next one
   task automatic cyc(string tag, bit r, bit w, logic [7:0] a, logic [2:0] s,
                      logic [31:0] d);
      logic [31:0] exp;
      rd_en = r; wr_en = w; addr = a; size = s; wdata = d;
      exp = r ? m_read(a) : 32'h0;
      if (w) m_write(a, s, d);
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0;
      check({tag, " rvalid"}, {31'b0, rvalid}, {31'b0, r});
      check({tag, " rdata"}, rdata, exp);
   endtask

   task automatic rd(string tag, logic [7:0] a);
      cyc(tag, 1'b1, 1'b0, a, 3'd4, 32'h0);
   endtask

   task automatic wr(string tag, logic [7:0] a, logic [2:0] s, logic [31:0] d);
      cyc(tag, 1'b0, 1'b1, a, s, d);
   endtask

   initial begin
      logic [7:0] holes [7] = '{8'h0C, 8'h40, 8'h44, 8'h50, 8'h54, 8'h10, 8'hFC};
      @(negedge clk);
      // R7: outputs quiet during reset
      for (int i = 0; i < 3; i++) begin
         check("R7 reset rvalid", {31'b0, rvalid}, 32'h0);
         check("R7 reset rdata", rdata, 32'h0);
         @(negedge clk);
      end
      rst_n = 1'b1;
      @(negedge clk);

      rd("R9 power-up status", 8'h08);
      rd("R1 control after reset", 8'h00);
      rd("R2 config word", 8'h04);
      check("R2 config value", m_read(8'h04), 32'h72);

      wr("R1 even write", 8'h00, 3'd4, 32'hFFFF_FFFE);
      rd("R1 bit0 only", 8'h00);
      wr("R1 set", 8'h00, 3'd1, 32'h0000_0003);
      rd("R1 set readback", 8'h00);

      wr("R2 write ignored", 8'h04, 3'd4, 32'h0);
      rd("R2 still fixed", 8'h04);

      wr("R4 word", 8'h08, 3'd4, 32'h1122_3344);
      for (int k = 0; k < 4; k++) rd("R5 lane read", 8'(8 + k));
      wr("R4 byte lane1", 8'h09, 3'd1, 32'hAABB_CCDD);
      rd("R4 after byte", 8'h08);
      wr("R4 half lane2", 8'h0A, 3'd2, 32'h5566_7788);
      rd("R4 after half", 8'h08);
      wr("R4 word lane3 truncated", 8'h0B, 3'd4, 32'hCAFE_F00D);
      rd("R4 after trunc", 8'h08);
      wr("R4 half lane3 truncated", 8'h0B, 3'd2, 32'h0000_99EE);
      rd("R4 after trunc2", 8'h08);
      check("R4 model value", m_stat, 32'hEE88_DD44);
      for (int k = 1; k < 4; k++) rd("R5 lane shift", 8'(8 + k));

      // R3: bad sizes drop the write
      wr("R3 size3", 8'h08, 3'd3, 32'h0);
      wr("R3 size0", 8'h00, 3'd0, 32'h0);
      wr("R3 size7", 8'h09, 3'd7, 32'h0);
      rd("R3 status kept", 8'h08);
      rd("R3 control kept", 8'h00);

      // R6: holes
      foreach (holes[i]) begin
         wr("R6 hole write", holes[i], 3'd4, 32'hFFFF_FFFF);
         rd("R6 hole read", holes[i]);
      end
      rd("R6 control untouched", 8'h00);
      rd("R6 status untouched", 8'h08);

      // R8: back-to-back and same-cycle read and write
      cyc("R8 rd+wr old value", 1'b1, 1'b1, 8'h00, 3'd4, 32'h0);
      rd("R8 new value", 8'h00);
      cyc("R8 rd+wr status", 1'b1, 1'b1, 8'h08, 3'd1, 32'h0000_0055);
      rd("R8 status new", 8'h08);
      cyc("R8 idle", 1'b0, 1'b0, 8'h00, 3'd4, 32'h0);

      // R7: functional reset mid-run
      wr("R7 set ctrl", 8'h00, 3'd4, 32'h1);
      rd("R7 status before", 8'h08);
      rst_n = 1'b0;
      m_ctrl = 1'b0;
      @(negedge clk);
      check("R7 mid reset rvalid", {31'b0, rvalid}, 32'h0);
      check("R7 mid reset rdata", rdata, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd("R7 control cleared", 8'h00);
      rd("R7 status kept", 8'h08);
      rd("R7 status lane kept", 8'h0B);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule